// File: doc/BRIEF.md
# Vector Status Register Controller

This block keeps the 64-bit status word of a vector unit. The word carries the active element count, the interruption index, a mask-mode flag, and one in-use flag and one changed flag for each of eight register pairs. A single command port, with one command per cycle, changes the word in several ways. It can load the count or the index from a signed 32-bit operand, clamping the value and reporting the clamp in a condition code. It can set the mask mode, copy the mode half-word out, zero the index, or restore the whole word from a 64-bit image after checking that the image is valid.

When the block restores a word, it sends the vector register file a one-cycle request for each register pair whose in-use flag goes from set to clear. The register file itself is not part of this block. A problem-state input controls how the changed flags are restored.

Field layout of the word: bits 63:49 are reserved and must be zero. Bit 48 is the mask-mode flag. Bits 47:32 hold the element count and bits 31:16 hold the interruption index. Bits 15:8 are the in-use flags, with bit 8+k for pair k. Bits 7:0 are the changed flags, with bit k for pair k. `SECTION_SIZE` (default 128) sets the largest element count. Command codes: 0 no-op, 1 load count, 2 load index, 3 set mask mode, 4 extract modes, 5 clear index, 6 restore, 7 no-op. The signed operand for the loads is `cmdOperand[31:0]`. Each command takes effect at the clock edge that samples it, and its results appear on the outputs from that edge onward.

Top module: `vstat_unit`

## Requirements
- R1: A synchronous active-high reset clears the status word, the condition code, the mode output, the exception flag and the clear-pair output to zero.
- R2: Load count (code 1) sets the condition code to 0 when the operand is zero, 1 when it is negative, 2 when it is greater than SECTION_SIZE, and 3 otherwise.
- R3: Load count writes bits 47:32 with 0 for a negative operand, SECTION_SIZE for an operand above it, and the operand otherwise. All other bits keep their values.
- R4: Load index (code 2) sets the condition code to 0 when the operand is zero and 1 when it is negative. Otherwise it sets 2 when the operand is below the element count held before the command, and 3 in the remaining cases.
- R5: Load index writes bits 31:16 with the operand clamped to the range 0 to SECTION_SIZE. All other bits keep their values.
- R6: Set mask mode (code 3) copies operand bit 0 into status bit 48 and leaves the other bits unchanged.
- R7: Extract modes (code 4) places status bits 63:48 on `modesOut`, which then holds that value until the next extract. The status word does not change.
- R8: Clear index (code 5) zeroes bits 31:16 and leaves every other bit unchanged.
- R9: A restore (code 6) is rejected if the operand has any bit of 63:49 set, if its bits 47:32 exceed SECTION_SIZE, or if its bits 31:16 are greater than or equal to SECTION_SIZE. A rejected restore pulses `specExc` for one cycle and leaves the status word unchanged.
- R10: An accepted restore loads the operand into the status word. In problem state the changed flags (7:0) are replaced by the operand's in-use flags (15:8).
- R11: On an accepted restore, bit k of `clearPair` pulses for one cycle when old bit 8+k was set and new bit 8+k is clear. `clearPair` is zero at all other times.
- R12: Only load count and load index change the condition code. Idle cycles and no-op codes change neither the condition code nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdOp | input | 3 | Command code |
| cmdOperand | input | 64 | Operand; low 32 bits signed for loads, full image for restore |
| probState | input | 1 | Problem state for restore |
| condCode | output | 2 | Condition code from the last load |
| specExc | output | 1 | One-cycle pulse on a rejected restore |
| modesOut | output | 16 | Mode half-word captured by the last extract |
| clearPair | output | 8 | One-cycle per-pair clear requests |
| statusOut | output | 64 | Current status word |

## Verification
The checker assertions cover properties that hold on every cycle. The reserved bits stay zero, and the count and index never exceed the section size. A rejected restore leaves the word unchanged, and clear requests appear only after a restore and only for pairs that were in use. The checker also tests the zero and negative load cases and the plain restore. Other behaviours need the bench's reference model and its command sequences. These are the exact clamp boundaries at and around SECTION_SIZE, and the index condition code measured against a count loaded earlier. They also include the problem-state rewrite of the changed flags and the condition code holding across commands that do not set it.

// File: rtl/vstat_pkg.sv
package vstat_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_LDCOUNT  = 3'd1,
    OP_LDINDEX  = 3'd2,
    OP_SETMASK  = 3'd3,
    OP_EXTRACT  = 3'd4,
    OP_CLRINDEX = 3'd5,
    OP_RESTORE  = 3'd6,
    OP_SPARE    = 3'd7
  } vsOp_e;

  typedef struct packed {
    logic ldCount;
    logic ldIndex;
    logic setMask;
    logic extract;
    logic clrIndex;
    logic restore;
  } vsStrobe_t;

  localparam int WORD_W   = 64;
  localparam int FIELD_W  = 16;
  localparam int PAIRS    = 8;
  localparam int CHG_LO   = 0;
  localparam int USE_LO   = CHG_LO + PAIRS;
  localparam int IDX_LO   = 16;
  localparam int CNT_LO   = IDX_LO + FIELD_W;
  localparam int MODE_BIT = CNT_LO + FIELD_W;
  localparam int RSV_LO   = MODE_BIT + 1;
  localparam int MODES_LO = WORD_W - FIELD_W;

endpackage

// File: rtl/vstat_clamp.sv
module vstat_clamp
  import vstat_pkg::*;
#(
  parameter int SECTION_SIZE = 128
) (
  input  logic [31:0]        operand,
  output logic               isZero,
  output logic               isNeg,
  output logic               isAbove,
  output logic [FIELD_W-1:0] clampVal
);

  logic signed [31:0] opS;

  always_comb begin
    opS      = operand;
    isZero   = (opS == 32'sd0);
    isNeg    = (opS < 32'sd0);
    isAbove  = (opS > SECTION_SIZE);
    if (isNeg)        clampVal = '0;
    else if (isAbove) clampVal = FIELD_W'(SECTION_SIZE);
    else              clampVal = operand[FIELD_W-1:0];
  end

endmodule

// File: rtl/vstat_ctrl.sv
module vstat_ctrl
  import vstat_pkg::*;
(
  input  logic      cmdValid,
  input  logic [2:0] cmdOp,
  output vsStrobe_t strb
);

  vsOp_e op;

  always_comb begin
    op   = vsOp_e'(cmdOp);
    strb = '0;
    if (cmdValid) begin
      unique case (op)
        OP_LDCOUNT:  strb.ldCount  = 1'b1;
        OP_LDINDEX:  strb.ldIndex  = 1'b1;
        OP_SETMASK:  strb.setMask  = 1'b1;
        OP_EXTRACT:  strb.extract  = 1'b1;
        OP_CLRINDEX: strb.clrIndex = 1'b1;
        OP_RESTORE:  strb.restore  = 1'b1;
        default:     strb          = '0;
      endcase
    end
  end

endmodule

// File: rtl/vstat_dpath.sv
module vstat_dpath
  import vstat_pkg::*;
#(
  parameter int SECTION_SIZE = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  vsStrobe_t          strb,
  input  logic [WORD_W-1:0]  operand,
  input  logic               probState,
  output logic [1:0]         condCode,
  output logic               specExc,
  output logic [FIELD_W-1:0] modesOut,
  output logic [PAIRS-1:0]   clearPair,
  output logic [WORD_W-1:0]  statusOut
);

  localparam logic [FIELD_W:0] SEC_EXT = (FIELD_W+1)'(SECTION_SIZE);

  logic [WORD_W-1:0]  statusQ;
  logic [1:0]         ccQ;
  logic               excQ;
  logic [FIELD_W-1:0] modesQ;
  logic [PAIRS-1:0]   clrQ;

  logic               opZero, opNeg, opAbove;
  logic [FIELD_W-1:0] clampVal;
  logic [FIELD_W-1:0] countNow;
  logic               belowCount;
  logic               rsvBad, cntBad, idxBad, restoreOk;
  logic [WORD_W-1:0]  restoreVal;
  logic [1:0]         countCc, indexCc;

  vstat_clamp #(.SECTION_SIZE(SECTION_SIZE)) i_clamp (
    .operand (operand[31:0]),
    .isZero  (opZero),
    .isNeg   (opNeg),
    .isAbove (opAbove),
    .clampVal(clampVal)
  );

  always_comb begin
    countNow   = statusQ[CNT_LO +: FIELD_W];
    belowCount = ($signed(operand[31:0]) < $signed({16'd0, countNow}));
    countCc    = opZero ? 2'd0 : opNeg ? 2'd1 : opAbove ? 2'd2 : 2'd3;
    indexCc    = opZero ? 2'd0 : opNeg ? 2'd1 : belowCount ? 2'd2 : 2'd3;

    rsvBad     = |operand[WORD_W-1:RSV_LO];
    cntBad     = {1'b0, operand[CNT_LO +: FIELD_W]} > SEC_EXT;
    idxBad     = {1'b0, operand[IDX_LO +: FIELD_W]} >= SEC_EXT;
    restoreOk  = !(rsvBad || cntBad || idxBad);

    restoreVal = operand;
    if (probState) restoreVal[CHG_LO +: PAIRS] = operand[USE_LO +: PAIRS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ <= '0;
      ccQ     <= '0;
      excQ    <= 1'b0;
      modesQ  <= '0;
      clrQ    <= '0;
    end else begin
      excQ <= 1'b0;
      clrQ <= '0;
      if (strb.ldCount) begin
        ccQ <= countCc;
        statusQ[CNT_LO +: FIELD_W] <= clampVal;
      end
      if (strb.ldIndex) begin
        ccQ <= indexCc;
        statusQ[IDX_LO +: FIELD_W] <= clampVal;
      end
      if (strb.setMask)  statusQ[MODE_BIT] <= operand[0];
      if (strb.extract)  modesQ <= statusQ[MODES_LO +: FIELD_W];
      if (strb.clrIndex) statusQ[IDX_LO +: FIELD_W] <= '0;
      if (strb.restore) begin
        if (restoreOk) begin
          statusQ <= restoreVal;
          clrQ    <= statusQ[USE_LO +: PAIRS] & ~restoreVal[USE_LO +: PAIRS];
        end else begin
          excQ <= 1'b1;
        end
      end
    end
  end

  assign condCode  = ccQ;
  assign specExc   = excQ;
  assign modesOut  = modesQ;
  assign clearPair = clrQ;
  assign statusOut = statusQ;

endmodule

// File: rtl/vstat_unit.sv
module vstat_unit
  import vstat_pkg::*;
#(
  parameter int SECTION_SIZE = 128
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [63:0] cmdOperand,
  input  logic        probState,
  output logic [1:0]  condCode,
  output logic        specExc,
  output logic [15:0] modesOut,
  output logic [7:0]  clearPair,
  output logic [63:0] statusOut
);

  vsStrobe_t strb;

  vstat_ctrl i_ctrl (
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .strb    (strb)
  );

  vstat_dpath #(.SECTION_SIZE(SECTION_SIZE)) i_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .operand  (cmdOperand),
    .probState(probState),
    .condCode (condCode),
    .specExc  (specExc),
    .modesOut (modesOut),
    .clearPair(clearPair),
    .statusOut(statusOut)
  );

endmodule

// File: rtl/vstat_check.sv
module vstat_check
  import vstat_pkg::*;
#(
  parameter int SECTION_SIZE = 128
) (
  input logic        clk,
  input logic        rst,
  input logic        cmdValid,
  input logic [2:0]  cmdOp,
  input logic [63:0] cmdOperand,
  input logic        probState,
  input logic [1:0]  condCode,
  input logic        specExc,
  input logic [7:0]  clearPair,
  input logic [63:0] statusOut
);

  localparam logic [16:0] SEC_EXT = 17'(SECTION_SIZE);

  logic ldCountCmd, restoreCmd, plainGoodRestore;

  always_comb begin
    ldCountCmd = cmdValid && (cmdOp == OP_LDCOUNT);
    restoreCmd = cmdValid && (cmdOp == OP_RESTORE);
    plainGoodRestore = restoreCmd && !probState && (cmdOperand[63:49] == '0)
                     && ({1'b0, cmdOperand[47:32]} <= SEC_EXT)
                     && ({1'b0, cmdOperand[31:16]} < SEC_EXT);
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    statusOut[63:49] == '0);  // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    {1'b0, statusOut[47:32]} <= SEC_EXT);  // R3

  AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (rst)
    {1'b0, statusOut[31:16]} <= SEC_EXT);  // R5

  AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ldCountCmd && (cmdOperand[31:0] == 32'd0) |=> condCode == 2'd0 && statusOut[47:32] == 16'd0);  // R2

  AST_COUNT_NEG: assert property (@(posedge clk) disable iff (rst)
    ldCountCmd && cmdOperand[31] |=> condCode == 2'd1 && statusOut[47:32] == 16'd0);  // R3

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    specExc |-> statusOut == $past(statusOut));  // R9

  AST_RESTORE_PLAIN: assert property (@(posedge clk) disable iff (rst)
    plainGoodRestore |=> statusOut == $past(cmdOperand));  // R10

  AST_CLEAR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (clearPair != 8'd0) |-> $past(restoreCmd));  // R11

  AST_CLEAR_INUSE: assert property (@(posedge clk) disable iff (rst)
    (clearPair & ~$past(statusOut[15:8])) == 8'd0);  // R11

endmodule

bind vstat_unit vstat_check #(.SECTION_SIZE(SECTION_SIZE)) i_check (
  .clk       (clk),
  .rst       (rst),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .cmdOperand(cmdOperand),
  .probState (probState),
  .condCode  (condCode),
  .specExc   (specExc),
  .clearPair (clearPair),
  .statusOut (statusOut)
);

// File: tb/test_vstat_unit.sv
`timescale 1ns/1ps
module test_vstat_unit;

  localparam int SEC = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [63:0] cmdOperand = '0;
  logic        probState = 1'b0;
  logic [1:0]  condCode;
  logic        specExc;
  logic [15:0] modesOut;
  logic [7:0]  clearPair;
  logic [63:0] statusOut;

  int checks = 0;
  int fails  = 0;

  logic [63:0] mStat  = '0;
  logic [1:0]  mCc    = '0;
  logic [15:0] mModes = '0;

  always #2 clk = ~clk;

  vstat_unit #(.SECTION_SIZE(SEC)) i_vstat_unit (
    .clk(clk), .rst(rst), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdOperand(cmdOperand), .probState(probState), .condCode(condCode),
    .specExc(specExc), .modesOut(modesOut), .clearPair(clearPair),
    .statusOut(statusOut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] clampOf(input logic signed [31:0] s);
    if (s < 0) return 16'd0;
    if (s > SEC) return 16'(SEC);
    return s[15:0];
  endfunction

  task automatic doCmd(input logic [2:0] op, input logic [63:0] opd, input logic prob);
    logic signed [31:0] s;
    logic [63:0] nv;
    logic [7:0]  expClr;
    logic        expSpec;
    logic        ok;
    string       ccTag, stTag;
    s = opd[31:0];
    expClr = '0;
    expSpec = 1'b0;
    ccTag = "R12";
    stTag = "R12";
    case (op)
      3'd1: begin
        mCc = (s == 0) ? 2'd0 : (s < 0) ? 2'd1 : (s > SEC) ? 2'd2 : 2'd3;
        mStat[47:32] = clampOf(s); ccTag = "R2"; stTag = "R3";
      end
      3'd2: begin
        mCc = (s == 0) ? 2'd0 : (s < 0) ? 2'd1 :
              (s < $signed({16'd0, mStat[47:32]})) ? 2'd2 : 2'd3;
        mStat[31:16] = clampOf(s); ccTag = "R4"; stTag = "R5";
      end
      3'd3: begin mStat[48] = opd[0]; stTag = "R6"; end
      3'd4: begin mModes = mStat[63:48]; stTag = "R7"; end
      3'd5: begin mStat[31:16] = '0; stTag = "R8"; end
      3'd6: begin
        ok = (opd[63:49] == '0) && (opd[47:32] <= SEC) && (opd[31:16] < SEC);
        if (ok) begin
          nv = opd;
          if (prob) nv[7:0] = opd[15:8];
          expClr = mStat[15:8] & ~nv[15:8];
          mStat = nv;
          stTag = "R10";
        end else begin
          expSpec = 1'b1;
          stTag = "R9";
        end
      end
      default: ;
    endcase
    cmdValid = 1'b1;
    cmdOp = op;
    cmdOperand = opd;
    probState = prob;
    @(negedge clk);
    cmdValid = 1'b0;
    chk(stTag, statusOut, mStat);
    chk(ccTag, 64'(condCode), 64'(mCc));
    chk("R9", 64'(specExc), 64'(expSpec));
    chk("R11", 64'(clearPair), 64'(expClr));
    chk("R7", 64'(modesOut), 64'(mModes));
  endtask

  function automatic logic [63:0] loadOpd();
    int sel = $urandom_range(0, 5);
    case (sel)
      0: return 64'(32'd0);
      1: return {32'd0, 32'(-$signed(32'($urandom_range(1, 1000))))};
      2: return {32'd0, 32'($urandom_range(SEC - 2, SEC + 2))};
      3: return {32'd0, 32'($urandom_range(1, SEC))};
      4: return {32'hdead_beef, 32'($urandom_range(SEC + 1, 70000))};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  function automatic logic [63:0] restoreOpd();
    logic [63:0] r = {$urandom, $urandom};
    int sel = $urandom_range(0, 5);
    r[63:49] = '0;
    r[47:32] = 16'($urandom_range(0, SEC));
    r[31:16] = 16'($urandom_range(0, SEC - 1));
    case (sel)
      0: r[63:49] = 15'(1 << $urandom_range(0, 14));
      1: r[47:32] = 16'($urandom_range(SEC + 1, 65535));
      2: r[31:16] = 16'($urandom_range(SEC, 65535));
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] op;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", statusOut, 64'd0);
    chk("R1", 64'(condCode), 64'd0);
    chk("R1", 64'(specExc), 64'd0);
    chk("R1", 64'(clearPair), 64'd0);
    chk("R1", 64'(modesOut), 64'd0);

    // R2 R3 boundaries of count loading
    doCmd(3'd1, 64'(32'd0), 1'b0);
    doCmd(3'd1, 64'(32'hffff_ffff), 1'b0);
    doCmd(3'd1, 64'(32'(SEC)), 1'b0);
    doCmd(3'd1, 64'(32'(SEC + 1)), 1'b0);
    doCmd(3'd1, 64'(32'h8000_0000), 1'b0);
    doCmd(3'd1, 64'(32'd5), 1'b0);
    // R4 R5 index against current count of 5
    doCmd(3'd2, 64'(32'd4), 1'b0);
    doCmd(3'd2, 64'(32'd5), 1'b0);
    doCmd(3'd2, 64'(32'(SEC + 9)), 1'b0);
    doCmd(3'd2, 64'(32'hffff_fff0), 1'b0);
    // R6 R7 R8 R12
    doCmd(3'd3, 64'd1, 1'b0);
    doCmd(3'd4, 64'd0, 1'b0);
    doCmd(3'd3, 64'hffff_fffe, 1'b0);
    doCmd(3'd5, 64'd0, 1'b0);
    doCmd(3'd0, 64'hffff, 1'b0);
    doCmd(3'd7, 64'hffff, 1'b0);
    // R10 R11 restores
    doCmd(3'd6, {15'd0, 1'b1, 16'(SEC), 16'(SEC - 1), 8'hff, 8'h00}, 1'b0);
    doCmd(3'd4, 64'd0, 1'b0);
    doCmd(3'd6, {15'd0, 1'b0, 16'd3, 16'd1, 8'h5a, 8'h00}, 1'b1);
    doCmd(3'd6, {15'd0, 1'b0, 16'd3, 16'(SEC), 8'h00, 8'h00}, 1'b0);
    doCmd(3'd6, {15'd0, 1'b0, 16'(SEC + 1), 16'd0, 8'h00, 8'h00}, 1'b0);
    doCmd(3'd6, {15'd1, 1'b0, 16'd0, 16'd0, 8'h00, 8'h00}, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      op = 3'($urandom_range(0, 7));
      if (op == 3'd6)
        doCmd(op, restoreOpd(), 1'($urandom_range(0, 1)));
      else
        doCmd(op, loadOpd(), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 7) == 0) begin
        @(negedge clk);
        chk("R12", statusOut, mStat);
        chk("R11", 64'(clearPair), 64'd0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule